// File: doc/BRIEF.md
# Preamble Duty-Cycle Frequency Error Meter

This block estimates how far the local oscillator sits from the received carrier. It watches the raw, unsynchronised demodulator output while an alternating 0/1 preamble arrives. A balanced preamble means the oscillator is on frequency. An oscillator that is off frequency skews the demodulated duty cycle toward ones or toward zeros. The block oversamples the demodulated bit on a strobe that runs at 16 times the bit rate. Each sample moves a signed up/down accumulator by one step. The value left after a fixed window of four bit times is the error estimate.

A measurement has two stages. First, a rising edge of the active-low chip-select line arms the meter, provided the feature-enable bit is set at that edge. Second, each rising edge of the trigger line opens one window. The window closes by itself after 64 strobes. The final accumulator value is then captured into an 8-bit two's-complement result register, together with a one-cycle valid pulse. The meter stays armed after a window, so the host can repeat a measurement with a new trigger edge and average the results.

The result is a status register, not a stream. There is no ready input and no back-pressure. A new capture simply overwrites the previous value, so the host must read the result when the valid pulse appears. All inputs are taken to be synchronous to `clk`.

Top module: `fe_duty_meter`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is 0, and the meter is disarmed.
- R2: A rising edge of `cs_n` arms the meter when `meas_en` is 1 at that edge. A rising edge of `cs_n` with `meas_en` at 0 disarms the meter and abandons any open window without a capture. While disarmed, trigger edges and strobes produce no capture.
- R3: While armed and idle, a rising edge of `trig_line` opens a window. The edge is detected as low in one clock and high in the next. The accumulator restarts at 0 when the window opens. Strobes before the trigger edge, and a strobe in the same clock as the edge, are not counted.
- R4: A window covers exactly SAMP_PER_BIT × WINDOW_BITS strobes (64 by default). The capture happens in the clock that follows the last of these strobes, and never earlier.
- R5: A strobe with `demod_bit` = 1 adds 1 to the accumulator, and a strobe with `demod_bit` = 0 subtracts 1. Clocks without a strobe leave the accumulator unchanged.
- R6: `result` is 8-bit two's complement, and 0 means a 50% duty cycle. It changes only at a capture.
- R7: The accumulator saturates at each step, at +127 and at −128. A step that would cross a limit leaves the value at that limit, and later steps move it back from the limit.
- R8: After a window completes, the meter stays armed. The next trigger edge starts a fresh window whose capture overwrites `result`.
- R9: Trigger edges that arrive while a window is open are ignored, including an edge in the clock of the closing strobe. Such an edge does not start a later window.
- R10: `result_valid` is high for exactly one clock per capture, in the same clock in which the new `result` first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | Sample strobe, one clock wide, at 16 × bit rate |
| demod_bit | input | 1 | Raw demodulator output bit |
| trig_line | input | 1 | Data-input line; a rising edge opens a window |
| cs_n | input | 1 | Active-low chip select; a rising edge arms or disarms |
| meas_en | input | 1 | Feature enable, sampled at the `cs_n` rising edge |
| result | output | 8 | Captured signed duty-cycle imbalance |
| result_valid | output | 1 | One-clock pulse when `result` is updated |

## Verification
Two functions can fall in the same clock: the closing strobe of a window and a new trigger edge. The bench provokes this by raising `trig_line` in the very clock of the 64th strobe. It then expects three things. The capture must equal the value computed from the 64 supplied samples. Exactly one valid pulse must appear. A further 64 strobes without a fresh edge must produce no capture and leave `result` unchanged. Saturation is tested on a second instance with a longer window, using a ones-then-zeros pattern. That pattern only gives the expected value if the clamp is applied at each step.

// File: rtl/fe_meter_pkg.sv
package fe_meter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } meas_state_t;

endpackage

// File: rtl/fe_edge_det.sv
module fe_edge_det #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic rise
);

  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= RST_LEVEL;
    else        line_q <= line;
  end

  assign rise = line & ~line_q;

endmodule

// File: rtl/fe_window_ctl.sv
module fe_window_ctl
  import fe_meter_pkg::*;
#(
  parameter int NSAMP = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_rise,
  input  logic arm_en,
  input  logic trig_rise,
  input  logic tick,
  output logic start,
  output logic step_en,
  output logic last
);

  localparam int IW = (NSAMP > 1) ? $clog2(NSAMP) : 1;

  meas_state_t state_q;
  logic [IW-1:0] idx_q;
  logic abort;

  assign abort   = arm_rise & ~arm_en;
  assign start   = (state_q == ST_ARMED) & trig_rise & ~abort;
  assign step_en = (state_q == ST_COUNT) & tick & ~abort;
  assign last    = step_en & (idx_q == IW'(NSAMP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (arm_rise) state_q <= ST_ARMED;
        ST_ARMED: if (trig_rise) begin
          state_q <= ST_COUNT;
          idx_q   <= '0;
        end
        ST_COUNT: if (tick) begin
          if (last) state_q <= ST_ARMED;
          else      idx_q   <= idx_q + 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an idle meter without enable never enters a window
  assert_idle_stays_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_COUNT));

  // R9: while counting, the window index only advances on strobes
  assert_idx_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COUNT) && !tick && !abort) |=> ((state_q == ST_COUNT) && $stable(idx_q)));

endmodule

// File: rtl/fe_sat_acc.sv
module fe_sat_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step_en,
  input  logic         up,
  output logic [W-1:0] next_val
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q;

  always_comb begin
    next_val = acc_q;
    if (clear) begin
      next_val = '0;
    end else if (step_en) begin
      if (up) next_val = (acc_q == MAXV) ? acc_q : acc_q + 1'b1;
      else    next_val = (acc_q == MINV) ? acc_q : acc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= next_val;
  end

  // R5: no strobe, no movement
  assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !clear) |=> $stable(acc_q));

  // R7: the upper limit holds under further up-steps
  assert_clamp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && up && acc_q == MAXV) |=> (acc_q == MAXV));

  // R7: the lower limit holds under further down-steps
  assert_clamp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && !up && acc_q == MINV) |=> (acc_q == MINV));

endmodule

// File: rtl/fe_duty_meter.sv
module fe_duty_meter #(
  parameter int SAMP_PER_BIT = 16,
  parameter int WINDOW_BITS  = 4,
  parameter int RES_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_tick,
  input  logic             demod_bit,
  input  logic             trig_line,
  input  logic             cs_n,
  input  logic             meas_en,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);

  localparam int NSAMP  = SAMP_PER_BIT * WINDOW_BITS;
  localparam int NLINES = 2;
  localparam logic [NLINES-1:0] IDLE_LEVELS = 2'b10;

  logic [NLINES-1:0] lines, rises;
  logic start, step_en, last;
  logic [RES_W-1:0] acc_next;

  assign lines = {cs_n, trig_line};

  for (genvar g = 0; g < NLINES; g++) begin : g_edge
    fe_edge_det #(.RST_LEVEL(IDLE_LEVELS[g])) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .line  (lines[g]),
      .rise  (rises[g])
    );
  end

  fe_window_ctl #(.NSAMP(NSAMP)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_rise  (rises[1]),
    .arm_en    (meas_en),
    .trig_rise (rises[0]),
    .tick      (samp_tick),
    .start     (start),
    .step_en   (step_en),
    .last      (last)
  );

  fe_sat_acc #(.W(RES_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .step_en  (step_en),
    .up       (demod_bit),
    .next_val (acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= last;
      if (last) result <= acc_next;
    end
  end

  // R10: a capture pulse never lasts two clocks
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6: the result moves only together with a capture pulse
  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

endmodule

// File: tb/fe_duty_meter_tb_top.sv
module fe_duty_meter_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, samp_tick, demod_bit, trig_line, cs_n, meas_en;
  logic [7:0] result, result_s;
  logic result_valid, result_valid_s;

  fe_duty_meter dut_i (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .demod_bit(demod_bit),
    .trig_line(trig_line), .cs_n(cs_n), .meas_en(meas_en),
    .result(result), .result_valid(result_valid)
  );

  fe_duty_meter #(.SAMP_PER_BIT(64)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .demod_bit(demod_bit),
    .trig_line(trig_line), .cs_n(cs_n), .meas_en(meas_en),
    .result(result_s), .result_valid(result_valid_s)
  );

  int checks = 0, fails = 0;
  int vcnt = 0, vcnt_s = 0;
  bit pv = 0, dbl = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (result_valid) vcnt++;
    if (result_valid_s) vcnt_s++;
    if (result_valid && pv) dbl = 1;
    pv = result_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_clamp(input int a, input bit b);
    int n;
    n = b ? a + 1 : a - 1;
    if (n > 127) n = 127;
    if (n < -128) n = -128;
    return n;
  endfunction

  function automatic int expect_pat(input logic [63:0] p);
    int a = 0;
    for (int i = 0; i < 64; i++) a = step_clamp(a, p[i]);
    return a;
  endfunction

  task automatic tick(input bit b);
    @(negedge clk); demod_bit = b; samp_tick = 1'b1;
    @(negedge clk); samp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic arm(input bit en);
    @(negedge clk); cs_n = 1'b0; meas_en = en;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); meas_en = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk); trig_line = 1'b1;
    @(negedge clk); trig_line = 1'b0;
  endtask

  task automatic run_main(input logic [63:0] p, input string req);
    int v0 = vcnt;
    trig();
    for (int i = 0; i < 64; i++) tick(p[i]);
    chk({req, " result"}, int'($signed(result)), expect_pat(p));
    chk({req, " valid count"}, vcnt - v0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v0, r0, sa;
    logic [63:0] p;
    void'($urandom(32'd4242));
    rst_n = 0; samp_tick = 0; demod_bit = 0; trig_line = 0; cs_n = 1; meas_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 result", int'(result), 0);
    chk("R1 valid", int'(result_valid), 0);

    // R2: an edge without enable leaves the meter disarmed
    arm(0);
    v0 = vcnt;
    trig();
    for (int i = 0; i < 64; i++) tick(1'b1);
    chk("R2 no capture when disarmed", vcnt - v0, 0);
    chk("R2 result untouched", int'(result), 0);

    arm(1);
    // R3: strobes before the trigger are ignored
    v0 = vcnt;
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk("R3 no capture before trigger", vcnt - v0, 0);
    run_main({32{2'b01}}, "R3 R5 alternating");

    // R4: no capture after 63 strobes, capture after the 64th
    v0 = vcnt;
    trig();
    for (int i = 0; i < 63; i++) tick(1'b1);
    chk("R4 no early capture", vcnt - v0, 0);
    tick(1'b1);
    chk("R4 capture at 64th", vcnt - v0, 1);
    chk("R4 R5 all ones", int'($signed(result)), 64);

    run_main(64'h0, "R5 R6 all zeros");

    // R8: back-to-back random windows overwrite the result
    for (int k = 0; k < 8; k++) begin
      p = {$urandom, $urandom};
      if (k == 2) p = p & {$urandom, $urandom};
      if (k == 5) p = p | {$urandom, $urandom};
      run_main(p, "R8 random window");
    end

    // R9: a trigger in the middle of a window is ignored
    v0 = vcnt;
    trig();
    for (int i = 0; i < 30; i++) tick(1'b1);
    trig();
    for (int i = 0; i < 34; i++) tick(1'b0);
    chk("R9 mid-window trigger result", int'($signed(result)), -4);
    chk("R9 mid-window single capture", vcnt - v0, 1);

    // R9: a trigger in the clock of the closing strobe
    v0 = vcnt;
    trig();
    sa = 0;
    for (int i = 0; i < 63; i++) begin
      tick(i[0]);
      sa = step_clamp(sa, i[0]);
    end
    @(negedge clk); demod_bit = 1; samp_tick = 1; trig_line = 1;
    @(negedge clk); samp_tick = 0; trig_line = 0;
    @(negedge clk);
    sa = step_clamp(sa, 1'b1);
    chk("R9 closing-cycle result", int'($signed(result)), sa);
    chk("R9 closing-cycle single capture", vcnt - v0, 1);
    r0 = int'(result);
    v0 = vcnt;
    for (int i = 0; i < 64; i++) tick(1'b0);
    chk("R9 closing-cycle edge starts nothing", vcnt - v0, 0);
    chk("R9 result kept", int'(result), r0);

    // R2: disarm aborts an open window
    v0 = vcnt;
    trig();
    for (int i = 0; i < 20; i++) tick(1'b1);
    arm(0);
    for (int i = 0; i < 60; i++) tick(1'b1);
    chk("R2 abort no capture", vcnt - v0, 0);
    chk("R2 abort result kept", int'(result), r0);

    // R7 saturation on the long-window instance
    arm(1);
    v0 = vcnt_s;
    trig();
    for (int i = 0; i < 256; i++) tick(1'b1);
    chk("R7 main all ones", int'($signed(result)), 64);
    chk("R7 clamp high", int'($signed(result_s)), 127);
    trig();
    for (int i = 0; i < 256; i++) tick(1'b0);
    chk("R7 clamp low", int'($signed(result_s)), -128);
    trig();
    sa = 0;
    for (int i = 0; i < 256; i++) begin
      tick(i < 200);
      sa = step_clamp(sa, i < 200);
    end
    chk("R7 stepwise clamp", int'($signed(result_s)), sa);
    chk("R7 long-window captures", vcnt_s - v0, 3);

    chk("R10 valid one clock wide", int'(dbl), 0);
    finish_run();
  end

endmodule